// File: doc/BRIEF.md
# Redundant Parameter Majority Decoder

This block pulls trustworthy byte values out of a parameter area that holds many redundant copies of every field, such as a buffer already read from a one-time-programmable region of a flash device. Getting the buffer from the flash is not part of this block. The block reads the buffer through a synchronous byte-read port. First it recovers two counts: the number of modes and the number of registers per mode. Then it recovers one value for every (mode, register) pair and writes it to an output table port, in mode-major order.

Each field is stored as eight copies. The vote is deliberately narrow. Only copies at positions 0 to 3 can be candidates. A candidate counts matches only among the copies that come after it, and it wins when that count is above four. For table entries a normal set of copies is tried first. If its vote fails, a second set holding bit-complemented copies is tried, and the winner of that set is complemented back before it is output. If a vote fails and nothing is left to fall back on, the whole decode stops with an error.

A `start` pulse begins a decode. `busy` is high while the decode runs. A one-cycle `done` pulse marks the end, and `err` tells whether the decode succeeded. The recovered counts stay on the outputs until the next start.

Top module: `rr_vote_decoder`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `tbl_we` are low.
- R2: The mode count is voted from buffer bytes 0..7 and the register count from bytes 8..15. After `done` they are presented on `mode_cnt` and `reg_cnt`. They keep those values until the next `start`, and a following decode replaces them.
- R3: A vote over copies c0..c7 picks the lowest position i in 0..3 whose value is equal to more than four of the copies c(i+1)..c7. A value repeated at least six times inside positions 0..7, with its first repeat at position 2 or lower, therefore wins even when the other copies are corrupt.
- R4: A value found only at copy positions 3..7 (five copies) does not win the vote, because candidate 3 has only four later matches.
- R5: Let S = modes*regs and e = mode*regs + reg. Copy k of entry e in the normal set is read at byte 16 + 2k*S + e. Each winning entry is written once with `tbl_idx` = e, in increasing e.
- R6: When the normal vote for an entry fails, the entry is voted from the complemented set at byte 16 + (2k+1)*S + e. The output value is the bitwise complement of that winner.
- R7: When both sets of an entry fail, `err` rises together with `done`, the decode stops, and no later entry is written.
- R8: When either count vote fails, the decode ends with `err` high and no table write.
- R9: `done` is a single-cycle pulse and `busy` is low when `done` is high. When modes*regs is 0, the decode ends with `done`, no error and no table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a decode when idle |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | AW | Buffer byte address |
| rd_data | input | DW | Buffer byte, valid one cycle after `rd_en` |
| tbl_we | output | 1 | Decoded entry write strobe |
| tbl_idx | output | 2*DW | Entry index mode*regs+reg |
| tbl_data | output | DW | Decoded entry value |
| mode_cnt | output | DW | Recovered mode count |
| reg_cnt | output | DW | Recovered register count |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle end-of-decode pulse |
| err | output | 1 | Decode aborted, no majority found |

## Verification
A clean buffer, where all copies agree, checks the count fields, the address layout of the normal set and the order of the writes. In a noisy buffer the corruption is placed at chosen positions. A value held in copies 2..7 must win and a value held only in copies 3..7 must lose, which separates this vote from a plain majority count. The complemented set holds a value different from the normal one, so the table port shows which set supplied each entry. Buffers in which both sets fail, in which a count fails, and in which the counts give zero entries check the abort and empty paths.

// File: rtl/rrv_pkg.sv
package rrv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SETTLE, ST_VOTE} rrv_state_e;
  typedef enum logic [1:0] {PH_MODES, PH_REGS, PH_ENTRY} rrv_phase_e;
endpackage

// File: rtl/rrv_vote.sv
module rrv_vote #(
  parameter int COPIES = 8,
  parameter int DW     = 8
) (
  input  logic [COPIES-1:0][DW-1:0] cp,
  output logic                      ok,
  output logic [DW-1:0]             val
);
  localparam int HALF = COPIES / 2;
  localparam int CNTW = $clog2(COPIES + 1);

  logic [HALF-1:0] win;

  // one match counter per candidate position, later copies only
  for (genvar i = 0; i < HALF; i++) begin : g_cand
    logic [CNTW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = i + 1; j < COPIES; j++) begin
        if (cp[j] == cp[i]) cnt = cnt + 1'b1;
      end
    end
    assign win[i] = (cnt > CNTW'(HALF));
  end

  // lowest winning position takes priority
  always_comb begin
    ok  = 1'b0;
    val = '0;
    for (int i = HALF - 1; i >= 0; i--) begin
      if (win[i]) begin
        ok  = 1'b1;
        val = cp[i];
      end
    end
  end
endmodule

// File: rtl/rrv_copy_buf.sv
module rrv_copy_buf #(
  parameter int COPIES = 8,
  parameter int DW     = 8,
  localparam int CW    = $clog2(COPIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CW-1:0]             wr_idx,
  input  logic [DW-1:0]             wr_data,
  output logic [COPIES-1:0][DW-1:0] cp
);
  for (genvar k = 0; k < COPIES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cp[k] <= '0;
      end else if (wr_en && (wr_idx == CW'(k))) begin
        cp[k] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rrv_ctrl.sv
module rrv_ctrl
  import rrv_pkg::*;
#(
  parameter int COPIES = 8,
  parameter int DW     = 8,
  parameter int AW     = 16,
  localparam int CW    = $clog2(COPIES),
  localparam int SW    = 2 * DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      vote_ok,
  input  logic [DW-1:0]             vote_val,
  input  logic [COPIES-1:0][DW-1:0] cp,
  output logic                      rd_en,
  output logic [AW-1:0]             rd_addr,
  output logic                      cap_en,
  output logic [CW-1:0]             cap_idx,
  output logic                      tbl_we,
  output logic [SW-1:0]             tbl_idx,
  output logic [DW-1:0]             tbl_data,
  output logic [DW-1:0]             mode_cnt,
  output logic [DW-1:0]             reg_cnt,
  output logic                      busy,
  output logic                      done,
  output logic                      err
);
  localparam int IW   = CW + 1;
  localparam int HALF = COPIES / 2;

  rrv_state_e      st_q, st_d;
  rrv_phase_e      ph_q, ph_d;
  logic [IW-1:0]   iss_q, iss_d;
  logic            inv_q, inv_d;
  logic [SW-1:0]   ent_q, ent_d;
  logic [SW-1:0]   set_q, set_d;
  logic [DW-1:0]   mcnt_q, mcnt_d;
  logic [DW-1:0]   rcnt_q, rcnt_d;
  logic            cap_en_q, cap_en_d;
  logic [CW-1:0]   cap_idx_q, cap_idx_d;
  logic            we_q, we_d;
  logic [SW-1:0]   idx_q, idx_d;
  logic [DW-1:0]   dat_q, dat_d;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic [31:0]     addr_full;
  logic [SW-1:0]   prod;

  // byte address of the copy being issued
  always_comb begin
    unique case (ph_q)
      PH_MODES: addr_full = 32'(iss_q);
      PH_REGS:  addr_full = 32'(COPIES) + 32'(iss_q);
      default:  addr_full = 32'(2 * COPIES)
                          + (32'(iss_q) * 32'd2 + 32'(inv_q)) * 32'(set_q)
                          + 32'(ent_q);
    endcase
  end

  assign prod = SW'(mcnt_q) * SW'(vote_val);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    iss_d     = iss_q;
    inv_d     = inv_q;
    ent_d     = ent_q;
    set_d     = set_q;
    mcnt_d    = mcnt_q;
    rcnt_d    = rcnt_q;
    cap_en_d  = 1'b0;
    cap_idx_d = cap_idx_q;
    we_d      = 1'b0;
    idx_d     = idx_q;
    dat_d     = dat_q;
    done_d    = 1'b0;
    err_d     = err_q;
    rd_en     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_FETCH;
          ph_d   = PH_MODES;
          iss_d  = '0;
          inv_d  = 1'b0;
          ent_d  = '0;
          set_d  = '0;
          mcnt_d = '0;
          rcnt_d = '0;
          err_d  = 1'b0;
        end
      end
      ST_FETCH: begin
        rd_en     = 1'b1;
        cap_en_d  = 1'b1;
        cap_idx_d = iss_q[CW-1:0];
        iss_d     = iss_q + 1'b1;
        if (iss_q == IW'(COPIES - 1)) st_d = ST_SETTLE;
      end
      ST_SETTLE: st_d = ST_VOTE;
      default: begin
        iss_d = '0;
        st_d  = ST_FETCH;
        unique case (ph_q)
          PH_MODES: begin
            if (!vote_ok) begin
              err_d = 1'b1; done_d = 1'b1; st_d = ST_IDLE;
            end else begin
              mcnt_d = vote_val;
              ph_d   = PH_REGS;
            end
          end
          PH_REGS: begin
            if (!vote_ok) begin
              err_d = 1'b1; done_d = 1'b1; st_d = ST_IDLE;
            end else begin
              rcnt_d = vote_val;
              set_d  = prod;
              inv_d  = 1'b0;
              ent_d  = '0;
              if (prod == '0) begin
                done_d = 1'b1; st_d = ST_IDLE;
              end else begin
                ph_d = PH_ENTRY;
              end
            end
          end
          default: begin
            if (vote_ok) begin
              we_d  = 1'b1;
              idx_d = ent_q;
              dat_d = inv_q ? ~vote_val : vote_val;
              inv_d = 1'b0;
              if (ent_q == set_q - 1'b1) begin
                done_d = 1'b1; st_d = ST_IDLE;
              end else begin
                ent_d = ent_q + 1'b1;
              end
            end else if (!inv_q) begin
              inv_d = 1'b1;
            end else begin
              err_d = 1'b1; done_d = 1'b1; st_d = ST_IDLE;
            end
          end
        endcase
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_MODES;
      iss_q     <= '0;
      inv_q     <= 1'b0;
      ent_q     <= '0;
      set_q     <= '0;
      mcnt_q    <= '0;
      rcnt_q    <= '0;
      cap_en_q  <= 1'b0;
      cap_idx_q <= '0;
      we_q      <= 1'b0;
      idx_q     <= '0;
      dat_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      iss_q     <= iss_d;
      inv_q     <= inv_d;
      ent_q     <= ent_d;
      set_q     <= set_d;
      mcnt_q    <= mcnt_d;
      rcnt_q    <= rcnt_d;
      cap_en_q  <= cap_en_d;
      cap_idx_q <= cap_idx_d;
      we_q      <= we_d;
      idx_q     <= idx_d;
      dat_q     <= dat_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign rd_addr  = addr_full[AW-1:0];
  assign cap_en   = cap_en_q;
  assign cap_idx  = cap_idx_q;
  assign tbl_we   = we_q;
  assign tbl_idx  = idx_q;
  assign tbl_data = dat_q;
  assign mode_cnt = mcnt_q;
  assign reg_cnt  = rcnt_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;

  logic [COPIES-1:0] match_vec;
  always_comb begin
    for (int k = 0; k < COPIES; k++) match_vec[k] = (cp[k] == vote_val);
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE));
  // R2
  counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start) |=> ($stable(mcnt_q) && $stable(rcnt_q)));
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> done_q);
  // R7
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !we_q);
  // R3
  vote_strength_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VOTE && vote_ok) |-> ($countones(match_vec) >= HALF + 2));
endmodule

// File: rtl/rr_vote_decoder.sv
module rr_vote_decoder #(
  parameter int COPIES = 8,
  parameter int DW     = 8,
  parameter int AW     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            tbl_we,
  output logic [2*DW-1:0] tbl_idx,
  output logic [DW-1:0]   tbl_data,
  output logic [DW-1:0]   mode_cnt,
  output logic [DW-1:0]   reg_cnt,
  output logic            busy,
  output logic            done,
  output logic            err
);
  localparam int CW = $clog2(COPIES);

  logic                      cap_en;
  logic [CW-1:0]             cap_idx;
  logic [COPIES-1:0][DW-1:0] cp;
  logic                      vote_ok;
  logic [DW-1:0]             vote_val;

  rrv_copy_buf #(.COPIES(COPIES), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_en), .wr_idx(cap_idx),
    .wr_data(rd_data), .cp(cp)
  );

  rrv_vote #(.COPIES(COPIES), .DW(DW)) u_vote (
    .cp(cp), .ok(vote_ok), .val(vote_val)
  );

  rrv_ctrl #(.COPIES(COPIES), .DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vote_ok(vote_ok), .vote_val(vote_val), .cp(cp),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .cap_en(cap_en), .cap_idx(cap_idx),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
    .mode_cnt(mode_cnt), .reg_cnt(reg_cnt),
    .busy(busy), .done(done), .err(err)
  );
endmodule

// File: tb/rr_vote_decoder_tb_top.sv
`timescale 1ns/1ps
module rr_vote_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        tbl_we;
  logic [15:0] tbl_idx;
  logic [7:0]  tbl_data;
  logic [7:0]  mode_cnt;
  logic [7:0]  reg_cnt;
  logic        busy;
  logic        done;
  logic        err;

  rr_vote_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_data(tbl_data), .mode_cnt(mode_cnt),
    .reg_cnt(reg_cnt), .busy(busy), .done(done), .err(err)
  );

  int total = 0;
  int bad   = 0;

  logic [7:0] mem [0:255];
  logic [7:0] got [0:63];
  int         wr_cnt;
  int         order_bad;
  int         last_idx;
  int         done_cycles;
  bit         done_seen;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[7:0]];
  end

  always @(negedge clk) begin
    if (tbl_we) begin
      got[tbl_idx[5:0]] = tbl_data;
      if (int'(tbl_idx) <= last_idx) order_bad++;
      last_idx = int'(tbl_idx);
      wr_cnt++;
    end
    if (done) begin
      done_cycles++;
      done_seen = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eaddr(int k, int inv, int e, int sz);
    return 16 + (2 * k + inv) * sz + e;
  endfunction

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = 8'(a) ^ 8'hA5;
  endtask

  task automatic set_field(input int base, input logic [7:0] v);
    for (int k = 0; k < 8; k++) mem[base + k] = v;
  endtask

  task automatic set_entry(input int inv, input int e, input int sz, input logic [7:0] v);
    for (int k = 0; k < 8; k++) mem[eaddr(k, inv, e, sz)] = v;
  endtask

  task automatic run_decode();
    int n;
    @(posedge clk);
    #1;
    wr_cnt = 0; order_bad = 0; last_idx = -1; done_cycles = 0; done_seen = 1'b0;
    for (int i = 0; i < 64; i++) got[i] = 8'h00;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done_seen && n < 3000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(!err, "R1 err", int'(err), 0);
    chk(!tbl_we, "R1 tbl_we", int'(tbl_we), 0);
  endtask

  task automatic t_clean();
    clear_mem();
    set_field(0, 8'd3);
    set_field(8, 8'd2);
    for (int e = 0; e < 6; e++) begin
      set_entry(0, e, 6, 8'(e * 17 + 5));
      set_entry(1, e, 6, ~8'(e * 17 + 5));
    end
    run_decode();
    chk(done_seen && !err, "R2 clean err", int'(err), 0);
    chk(mode_cnt == 8'd3, "R2 mode_cnt", int'(mode_cnt), 3);
    chk(reg_cnt == 8'd2, "R2 reg_cnt", int'(reg_cnt), 2);
    chk(wr_cnt == 6, "R5 write count", wr_cnt, 6);
    chk(order_bad == 0, "R5 write order", order_bad, 0);
    for (int e = 0; e < 6; e++)
      chk(got[e] == 8'(e * 17 + 5), "R5 entry", int'(got[e]), e * 17 + 5);
    chk(done_cycles == 1, "R9 done pulse width", done_cycles, 1);
    chk(!busy, "R9 busy after done", int'(busy), 0);
  endtask

  task automatic t_noisy();
    clear_mem();
    // mode field: copy0 corrupt, copies 1..7 hold 1
    set_field(0, 8'd1);
    mem[0] = 8'h77;
    // reg field: copy1 corrupt
    set_field(8, 8'd3);
    mem[9] = 8'h44;
    // entry 0: copies 2..7 hold 0x3C, 0..1 junk
    for (int k = 2; k < 8; k++) mem[eaddr(k, 0, 0, 3)] = 8'h3C;
    set_entry(1, 0, 3, 8'h00);
    // entry 1: normal holds 0x5A in copies 3..7 only; complemented set holds ~0x96
    for (int k = 3; k < 8; k++) mem[eaddr(k, 0, 1, 3)] = 8'h5A;
    set_entry(1, 1, 3, ~8'h96);
    // entry 2: clean normal, junk complemented set
    set_entry(0, 2, 3, 8'hC1);
    run_decode();
    chk(!err, "R3 noisy err", int'(err), 0);
    chk(mode_cnt == 8'd1, "R3 mode_cnt with corrupt copy0", int'(mode_cnt), 1);
    chk(reg_cnt == 8'd3, "R3 reg_cnt with corrupt copy1", int'(reg_cnt), 3);
    chk(got[0] == 8'h3C, "R3 entry from copies 2..7", int'(got[0]), 'h3C);
    chk(got[1] == 8'h96, "R4 copies 3..7 lose, R6 complemented set used", int'(got[1]), 'h96);
    chk(got[2] == 8'hC1, "R5 entry 2", int'(got[2]), 'hC1);
    chk(wr_cnt == 3, "R5 noisy write count", wr_cnt, 3);
  endtask

  task automatic t_both_fail();
    clear_mem();
    set_field(0, 8'd2);
    set_field(8, 8'd2);
    set_entry(0, 0, 4, 8'h11);
    // entry 1: both sets left as junk
    set_entry(0, 2, 4, 8'h22);
    set_entry(0, 3, 4, 8'h33);
    run_decode();
    chk(done_seen && err, "R7 err on double failure", int'(err), 1);
    chk(wr_cnt == 1, "R7 writes before abort", wr_cnt, 1);
    chk(got[0] == 8'h11, "R7 entry before abort", int'(got[0]), 'h11);
    chk(!busy, "R7 stopped", int'(busy), 0);
  endtask

  task automatic t_count_fail();
    clear_mem();
    set_field(0, 8'd2);
    // reg field left as junk
    run_decode();
    chk(done_seen && err, "R8 err on count failure", int'(err), 1);
    chk(wr_cnt == 0, "R8 no writes", wr_cnt, 0);
    clear_mem();
    // mode field in copies 3..7 only
    for (int k = 3; k < 8; k++) mem[k] = 8'd2;
    set_field(8, 8'd2);
    run_decode();
    chk(done_seen && err, "R8 R4 mode count from copies 3..7 fails", int'(err), 1);
    chk(wr_cnt == 0, "R8 no writes after mode failure", wr_cnt, 0);
  endtask

  task automatic t_zero();
    clear_mem();
    set_field(0, 8'd0);
    set_field(8, 8'd5);
    run_decode();
    chk(done_seen && !err, "R9 zero entries no error", int'(err), 0);
    chk(wr_cnt == 0, "R9 zero entries no writes", wr_cnt, 0);
    chk(reg_cnt == 8'd5, "R2 reg_cnt replaced", int'(reg_cnt), 5);
    chk(mode_cnt == 8'd0, "R2 mode_cnt replaced", int'(mode_cnt), 0);
    repeat (5) @(negedge clk);
    chk(reg_cnt == 8'd5, "R2 reg_cnt held while idle", int'(reg_cnt), 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    rd_data = 8'h00;
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_noisy();
    t_both_fail();
    t_count_fail();
    t_zero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule